// File: doc/BRIEF.md
# Programmable Four-Input Logic Cell

This block is a single programmable logic cell of the kind tiled across a reconfigurable fabric. A sixteen-entry truth table, held in configuration storage, is read through a binary multiplexer tree steered by four data inputs. The cell can therefore produce any Boolean function of those four inputs. One more configuration bit decides whether the cell drives the table result straight to its output or drives the copy captured by a D flip-flop on the previous rising clock edge.

The cell is set up through a one-bit serial port. While the load enable is high, each rising edge shifts one bit into a seventeen-bit configuration register. While loading is under way the cell output is forced low. Once the enable drops, the stored setup does not change, and the cell acts as fixed logic until the next load or reset. The mux tree uses the least significant data input at its first level, so adjacent table entries form the first pairs. Higher inputs choose among the results further up the tree.

Top module: `lutcell_top`

## Requirements
- R1: A synchronous active-high reset clears every configuration bit and the flip-flop, so after reset cell_out is 0 for every data input value.
- R2: While cfg_en is high, each rising edge shifts cfg_din into the configuration register. Seventeen bits are sent MSB-first: table entries 15 down to 0 come first and the output-mode bit comes last.
- R3: cell_out is 0 in every cycle in which cfg_en is high.
- R4: With the mode bit 0 (combinational) and cfg_en low, cell_out equals table entry {d_in[3],d_in[2],d_in[1],d_in[0]} (d_in[3] most significant), with no clock delay.
- R5: With the mode bit 1 (registered) and cfg_en low, cell_out equals the table entry selected by d_in at the previous rising edge.
- R6: The flip-flop is cleared on every edge with cfg_en high, so right after a load into registered mode cell_out is 0 until the first edge with cfg_en low.
- R7: While cfg_en is low, the configuration does not change, however d_in and cfg_din move.
- R8: With d_in[3:2]=00, A=d_in[1] and B=d_in[0], a table whose entries for AB=00,01,10,11 are 0111 gives OR, 0001 gives AND, 1110 gives NAND, 1111 gives constant 1 and 0000 gives constant 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Serial configuration load enable |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| d_in | input | 4 | Data inputs that select the table entry |
| cell_out | output | 1 | Cell output, combinational or registered |

## Verification
The hardest state to reach from the ports is an exact, known configuration word. A single misplaced shift moves every table entry and swaps the mode bit with entry 0. The stimulus sends complete seventeen-bit frames, including the five named gate patterns and random tables in both modes. It then scans all sixteen select values through the combinational path. Registered-mode runs follow each load directly, so the cleared first cycle after loading is exercised every time.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

    localparam int LC_INPUTS = 4;
    localparam int LC_TBL    = 1 << LC_INPUTS;
    localparam int LC_CFG    = LC_TBL + 1;

    typedef enum logic {
        LC_COMB = 1'b0,
        LC_REG  = 1'b1
    } lc_mode_e;

    typedef struct packed {
        logic [LC_TBL-1:0] tbl;
        logic              use_reg;
    } lc_cfg_t;

    // First node index of tree level l in a flat array holding n_sel+1 levels
    function automatic int lvl_base(input int n_sel, input int l);
        return (2 << n_sel) - (2 << (n_sel - l));
    endfunction

endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
    parameter int WIDTH = lutcell_pkg::LC_CFG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= {word_q[WIDTH-2:0], bit_in};
        end
    end

endmodule

// File: rtl/lc_mux_tree.sv
module lc_mux_tree #(
    parameter int N_SEL = lutcell_pkg::LC_INPUTS
) (
    input  logic [(1<<N_SEL)-1:0] tbl,
    input  logic [N_SEL-1:0]      sel,
    output logic                  y
);
    import lutcell_pkg::*;

    localparam int LEAVES = 1 << N_SEL;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] node;

    // Level 0 is the table, and each higher level halves the node count.
    always_comb begin
        node = '0;
        node[LEAVES-1:0] = tbl;
        for (int l = 0; l < N_SEL; l++) begin
            for (int k = 0; k < (LEAVES >> (l + 1)); k++) begin
                node[lvl_base(N_SEL, l + 1) + k] =
                    sel[l] ? node[lvl_base(N_SEL, l) + 2*k + 1]
                           : node[lvl_base(N_SEL, l) + 2*k];
            end
        end
    end

    assign y = node[NODES-1];

endmodule

// File: rtl/lc_out_stage.sv
module lc_out_stage
    import lutcell_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  lc_mode_e mode,
    input  logic     lut_y,
    output logic     cell_out
);

    logic ff_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            ff_q <= 1'b0;
        end else begin
            ff_q <= lut_y;
        end
    end

    always_comb begin
        if (hold) begin
            cell_out = 1'b0;
        end else begin
            unique case (mode)
                LC_REG:  cell_out = ff_q;
                default: cell_out = lut_y;
            endcase
        end
    end

endmodule

// File: rtl/lutcell_top.sv
module lutcell_top
    import lutcell_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_en,
    input  logic                 cfg_din,
    input  logic [LC_INPUTS-1:0] d_in,
    output logic                 cell_out
);

    logic [LC_CFG-1:0] cfg_raw;
    lc_cfg_t           cfg;
    logic              lut_y;

    lc_cfg_chain #(.WIDTH(LC_CFG)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .bit_in   (cfg_din),
        .word_q   (cfg_raw)
    );

    assign cfg = lc_cfg_t'(cfg_raw);

    lc_mux_tree #(.N_SEL(LC_INPUTS)) u_tree (
        .tbl (cfg.tbl),
        .sel (d_in),
        .y   (lut_y)
    );

    lc_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .hold     (cfg_en),
        .mode     (lc_mode_e'(cfg.use_reg)),
        .lut_y    (lut_y),
        .cell_out (cell_out)
    );

endmodule

// File: rtl/lutcell_chk.sv
module lutcell_chk
    import lutcell_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_en,
    input logic                 cfg_din,
    input logic [LC_INPUTS-1:0] d_in,
    input logic                 cell_out,
    input logic [LC_CFG-1:0]    cfg_raw,
    input logic                 lut_y
);

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> (cell_out == 1'b0)); // R3

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg_raw[0] == $past(cfg_din))); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_raw)); // R7

    AST_COMB_SEL: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !cfg_raw[0]) |->
            (cell_out == cfg_raw[{1'b0, d_in} + 5'd1])); // R4

    AST_REG_DELAY: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && cfg_raw[0] && !$past(cfg_en) && !$past(rst)) |->
            (cell_out == $past(lut_y))); // R5

    AST_REG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cfg_en ##1 (!cfg_en && cfg_raw[0])) |-> (cell_out == 1'b0)); // R6

endmodule

bind lutcell_top lutcell_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .d_in     (d_in),
    .cell_out (cell_out),
    .cfg_raw  (cfg_raw),
    .lut_y    (lut_y)
);

// File: tb/sim_lutcell_top.sv
`timescale 1ns/1ps
module sim_lutcell_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] d_in = 4'd0;
    logic       cell_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [15:0] m_tbl = '0;
    logic        m_mode = 1'b0;
    logic        m_ff = 1'b0;

    always #2 clk = ~clk;

    lutcell_top u0 (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .d_in     (d_in),
        .cell_out (cell_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_tbl  <= '0;
            m_mode <= 1'b0;
            m_ff   <= 1'b0;
        end else if (cfg_en) begin
            m_tbl  <= {m_tbl[14:0], m_mode};
            m_mode <= cfg_din;
            m_ff   <= 1'b0;
        end else begin
            m_ff   <= m_tbl[d_in];
        end
    end

    function automatic logic model_out();
        if (cfg_en) return 1'b0;
        if (m_mode) return m_ff;
        return m_tbl[d_in];
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cell_out=%b expected %b (d_in=%h)", tag, act, exp, d_in);
        end
    endtask

    // One cycle: drive after the falling edge, compare with the model 1 ns later
    task automatic cyc(input logic en, input logic din, input logic [3:0] d);
        string tag;
        @(negedge clk);
        cfg_en = en; cfg_din = din; d_in = d;
        #1;
        if (rst) tag = "R1";
        else if (en) tag = "R3";
        else if (m_mode) tag = "R5";
        else tag = "R4";
        chk(tag, cell_out, model_out());
    endtask

    task automatic load(input logic [15:0] tbl, input logic mode);
        for (int i = 15; i >= 0; i--) cyc(1'b1, tbl[i], 4'($urandom));
        cyc(1'b1, mode, 4'($urandom));
    endtask

    // Bring out the stored table through the combinational path
    task automatic scan(input string tag, input logic [15:0] exp_tbl);
        for (int i = 0; i < 16; i++) begin
            cyc(1'b0, 1'($urandom), 4'(i));
            chk(tag, cell_out, exp_tbl[i]);
        end
    endtask

    // pat is written for AB = 00,01,10,11 from left to right
    task automatic gate(input string name, input logic [3:0] pat);
        logic [15:0] t;
        t = '0;
        for (int ab = 0; ab < 4; ab++) t[ab] = pat[3-ab];
        load(t, 1'b0);
        for (int ab = 0; ab < 4; ab++) begin
            cyc(1'b0, 1'b0, 4'(ab));
            chk({"R8 ", name}, cell_out, pat[3-ab]);
        end
    endtask

    initial begin
        logic [15:0] t;
        logic        prev;
        repeat (3) cyc(1'b0, 1'b1, 4'($urandom));
        rst = 1'b0;
        for (int i = 0; i < 16; i += 5) begin
            cyc(1'b0, 1'b0, 4'(i));
            chk("R1 reset", cell_out, 1'b0);
        end

        gate("OR",    4'b0111);
        gate("AND",   4'b0001);
        gate("NAND",  4'b1110);
        gate("TRUE",  4'b1111);
        gate("FALSE", 4'b0000);

        // R2: bit order, entry 15 sent first, mode last
        load(16'h8001, 1'b0);
        scan("R2 order", 16'h8001);
        load(16'h4C3A, 1'b0);
        scan("R2 pattern", 16'h4C3A);

        // R7: a long run with cfg_en low and moving cfg_din leaves the table intact
        repeat (40) cyc(1'b0, 1'($urandom), 4'($urandom));
        scan("R7 hold", 16'h4C3A);

        // R4 and R5 under random tables
        for (int n = 0; n < 6; n++) begin
            t = 16'($urandom);
            load(t, 1'b0);
            scan("R4 comb", t);
            load(t, 1'b1);
            cyc(1'b0, 1'b0, 4'($urandom));
            chk("R6 first cycle", cell_out, 1'b0);
            prev = t[d_in];
            for (int k = 0; k < 30; k++) begin
                cyc(1'b0, 1'($urandom), 4'($urandom));
                chk("R5 delay", cell_out, prev);
                prev = t[d_in];
            end
        end

        // R3: output held low during a load even with an all-ones table
        load(16'hFFFF, 1'b0);
        cyc(1'b1, 1'b1, 4'hF);
        chk("R3 load", cell_out, 1'b0);
        cyc(1'b0, 1'b0, 4'hF);

        // R1: reset after a load clears the setup
        load(16'hFFFF, 1'b1);
        rst = 1'b1;
        cyc(1'b0, 1'b0, 4'h3);
        rst = 1'b0;
        scan("R1 reload reset", 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule